// File: doc/BRIEF.md
# Sideband Control-Status Access Bridge

This block lets a host reach two kinds of remote unit, a clock unit and a PHY unit, over a simple request/response sideband. The host sees three registers: a combined control/status word, an address word whose upper half holds a 16-bit register index, and a data word. For a write the data word holds the value to send. For a read the host clears the data word first, and the result is loaded into it.

The host writes the control word with its busy bit set to launch an access. That one write also picks the destination and whether the access is a read or a write. The destination picks the operation class: the clock unit gets configuration-space operations and the PHY unit gets I/O-space operations. The bridge presents the request and holds it until the destination accepts it. It then waits for the response, captures the response-fail flag into the control word and, for a successful read, the returned data. Busy then drops. While busy is set, every host write is dropped.

Top module: `sbcs_bridge`

## Requirements
- R1: After reset the control, address and data registers all read zero, and no request is presented.
- R2: The request index is bits [31:16] of the address register (host_sel 1). Bits [15:0] are not sent.
- R3: Control bit 16 selects the destination: 0 is the clock unit, with read opcode 3'b110 (configuration read), and 1 is the PHY unit, with read opcode 3'b010 (I/O read).
- R4: Control bit 8 set makes the access a write. It sets opcode bit 0 (3'b111 for the clock unit, 3'b011 for the PHY unit), and the data register (host_sel 2) is sent as write data.
- R5: A control write (host_sel 0) with bit 0 set while idle sets busy and raises sb_req_valid on the next cycle. The request and its fields stay stable until a cycle with sb_req_ready high.
- R6: After acceptance, busy (control bit 0) clears on the cycle after sb_rsp_valid is seen.
- R7: Control bit 1 reports the response-fail flag of the last completed access. A launch clears it on the next cycle.
- R8: A successful read loads sb_rsp_data into the data register at completion. A failed read or any write leaves the data register unchanged.
- R9: While busy, host writes to any register are dropped and the access in flight is undisturbed.
- R10: A control write with bit 0 clear updates the destination and write bits but starts no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 2 | Register select: 0 control, 1 address, 2 data |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Selected register contents (combinational) |
| sb_req_valid | output | 1 | Request presented to the destination |
| sb_req_ready | input | 1 | Destination accepts the request |
| sb_req_dest | output | 1 | 0 clock unit, 1 PHY unit |
| sb_req_opcode | output | 3 | Operation code |
| sb_req_index | output | 16 | Register index |
| sb_req_wdata | output | 32 | Write data |
| sb_rsp_valid | input | 1 | Response strobe |
| sb_rsp_fail | input | 1 | Response reports failure |
| sb_rsp_data | input | 32 | Read data returned |

## Verification
A launch shows up at the sideband one clock after the control write. Completion shows up in the readable registers one clock after the response strobe. Acceptance moves the bridge into its waiting phase on the clock that samples ready. The bench drives every input on the falling edge. Its reference model advances on the rising edge. It compares the request outputs and reads back registers on the following falling edge, so each result is sampled exactly one register stage after its cause.

// File: rtl/sbcs_pkg.sv
package sbcs_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} seq_st_e;

  localparam logic [1:0] SEL_CTL  = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;

  localparam int CTL_BUSY_BIT = 0;
  localparam int CTL_FAIL_BIT = 1;
  localparam int CTL_WR_BIT   = 8;
  localparam int CTL_DEST_BIT = 16;

  localparam logic [2:0] OPC_CFG_RD = 3'b110;
  localparam logic [2:0] OPC_IO_RD  = 3'b010;
endpackage

// File: rtl/sbcs_seq.sv
module sbcs_seq
  import sbcs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic req_ready,
  input  logic rsp_valid,
  output logic busy,
  output logic req_valid,
  output logic done
);
  seq_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (launch)    st_d = ST_REQ;
      ST_REQ:  if (req_ready) st_d = ST_WAIT;
      ST_WAIT: if (rsp_valid) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign busy      = (st_q != ST_IDLE);
  assign req_valid = (st_q == ST_REQ);
  assign done      = (st_q == ST_WAIT) && rsp_valid;

  // R5: request held until accepted
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid);
endmodule

// File: rtl/sbcs_regs.sv
module sbcs_regs
  import sbcs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [1:0]        host_sel,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic              rsp_fail,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              launch,
  output logic              dest_q,
  output logic              wr_q,
  output logic [DATA_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);
  logic              fail_q, fail_d, dest_d, wr_d;
  logic [DATA_W-1:0] addr_d, data_d, ctl_word;
  logic              we_ok, ctl_we, addr_we, data_we;

  assign we_ok   = host_we && !busy;
  assign ctl_we  = we_ok && (host_sel == SEL_CTL);
  assign addr_we = we_ok && (host_sel == SEL_ADDR);
  assign data_we = we_ok && (host_sel == SEL_DATA);
  assign launch  = ctl_we && host_wdata[CTL_BUSY_BIT];

  always_comb begin
    dest_d = dest_q;
    wr_d   = wr_q;
    fail_d = fail_q;
    addr_d = addr_q;
    data_d = data_q;
    if (ctl_we) begin
      dest_d = host_wdata[CTL_DEST_BIT];
      wr_d   = host_wdata[CTL_WR_BIT];
    end
    if (launch)  fail_d = 1'b0;
    if (addr_we) addr_d = host_wdata;
    if (data_we) data_d = host_wdata;
    if (done) begin
      fail_d = rsp_fail;
      if (!wr_q && !rsp_fail) data_d = rsp_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_q <= 1'b0;
      wr_q   <= 1'b0;
      fail_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      dest_q <= dest_d;
      wr_q   <= wr_d;
      fail_q <= fail_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  always_comb begin
    ctl_word               = '0;
    ctl_word[CTL_BUSY_BIT] = busy;
    ctl_word[CTL_FAIL_BIT] = fail_q;
    ctl_word[CTL_WR_BIT]   = wr_q;
    ctl_word[CTL_DEST_BIT] = dest_q;
    case (host_sel)
      SEL_CTL:  host_rdata = ctl_word;
      SEL_ADDR: host_rdata = addr_q;
      SEL_DATA: host_rdata = data_q;
      default:  host_rdata = '0;
    endcase
  end

  // R7: launch clears the fail flag
  p_fail_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !fail_q);
  // R7: completion captures the response-fail flag
  p_fail_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> fail_q == $past(rsp_fail));
  // R9: no register moves while an access is in flight and not completing
  p_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> $stable(addr_q) && $stable(data_q) && $stable(dest_q) && $stable(wr_q));
endmodule

// File: rtl/sbcs_bridge.sv
module sbcs_bridge
  import sbcs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [1:0]        host_sel,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              sb_req_valid,
  input  logic              sb_req_ready,
  output logic              sb_req_dest,
  output logic [2:0]        sb_req_opcode,
  output logic [IDX_W-1:0]  sb_req_index,
  output logic [DATA_W-1:0] sb_req_wdata,
  input  logic              sb_rsp_valid,
  input  logic              sb_rsp_fail,
  input  logic [DATA_W-1:0] sb_rsp_data
);
  localparam int IDX_LSB = DATA_W - IDX_W;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              launch, busy, done, dest_q, wr_q;
  logic [DATA_W-1:0] addr_q, data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sbcs_regs #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .host_we    (host_we),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .busy       (busy),
    .done       (done),
    .rsp_fail   (sb_rsp_fail),
    .rsp_data   (sb_rsp_data),
    .launch     (launch),
    .dest_q     (dest_q),
    .wr_q       (wr_q),
    .addr_q     (addr_q),
    .data_q     (data_q)
  );

  sbcs_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .launch    (launch),
    .req_ready (sb_req_ready),
    .rsp_valid (sb_rsp_valid),
    .busy      (busy),
    .req_valid (sb_req_valid),
    .done      (done)
  );

  assign sb_req_dest   = dest_q;
  assign sb_req_opcode = (dest_q ? OPC_IO_RD : OPC_CFG_RD) | {2'b00, wr_q};
  assign sb_req_index  = addr_q[DATA_W-1:IDX_LSB];
  assign sb_req_wdata  = data_q;

  // R5: a launching control write raises the request next cycle
  p_launch_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    host_we && host_sel == SEL_CTL && host_wdata[CTL_BUSY_BIT] && !busy |=> sb_req_valid);
  // R5: request fields stable while waiting for acceptance
  p_req_stable_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    sb_req_valid && !sb_req_ready |=> $stable(sb_req_opcode) && $stable(sb_req_index) && $stable(sb_req_wdata));
  // R6: a response while waiting ends busy
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    busy && !sb_req_valid && sb_rsp_valid |=> !busy);
  // R10: no request without busy
  p_idle_noreq_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    !busy |-> !sb_req_valid);
endmodule

// File: tb/sbcs_bridge_tb.sv
module sbcs_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        sb_req_valid, sb_req_dest;
  logic        sb_req_ready = 1'b0;
  logic [2:0]  sb_req_opcode;
  logic [15:0] sb_req_index;
  logic [31:0] sb_req_wdata;
  logic        sb_rsp_valid = 1'b0;
  logic        sb_rsp_fail = 1'b0;
  logic [31:0] sb_rsp_data = '0;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sbcs_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .sb_req_valid(sb_req_valid), .sb_req_ready(sb_req_ready),
    .sb_req_dest(sb_req_dest), .sb_req_opcode(sb_req_opcode),
    .sb_req_index(sb_req_index), .sb_req_wdata(sb_req_wdata),
    .sb_rsp_valid(sb_rsp_valid), .sb_rsp_fail(sb_rsp_fail),
    .sb_rsp_data(sb_rsp_data)
  );

  // reference model: phase 0 idle, 1 presenting, 2 awaiting response
  int          m_ph;
  bit          m_dest, m_wr, m_fail;
  logic [31:0] m_addr, m_data;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_dest = 0; m_wr = 0; m_fail = 0; m_addr = '0; m_data = '0;
    end else begin
      if (m_ph == 0) begin
        if (host_we) begin
          if (host_sel == 2'd0) begin
            m_dest = host_wdata[16];
            m_wr   = host_wdata[8];
            if (host_wdata[0]) begin m_ph = 1; m_fail = 0; end
          end else if (host_sel == 2'd1) m_addr = host_wdata;
          else if (host_sel == 2'd2) m_data = host_wdata;
        end
      end else if (m_ph == 1) begin
        if (sb_req_ready) m_ph = 2;
      end else if (sb_rsp_valid) begin
        m_ph = 0;
        m_fail = sb_rsp_fail;
        if (!m_wr && !sb_rsp_fail) m_data = sb_rsp_data;
      end
    end
  end

  function automatic logic [2:0] exp_opc(bit d, bit w);
    return (d ? 3'b010 : 3'b110) | {2'b00, w};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-clock comparison of the sideband outputs (R2 R3 R4 R5)
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R5 req_valid", {31'b0, sb_req_valid}, {31'b0, m_ph == 1});
      if (m_ph == 1) begin
        chk("R3 opcode", {29'b0, sb_req_opcode}, {29'b0, exp_opc(m_dest, m_wr)});
        chk("R2 index", {16'b0, sb_req_index}, {16'b0, m_addr[31:16]});
        chk("R4 wdata", sb_req_wdata, m_data);
      end
    end
  end

  task automatic wr(logic [1:0] s, logic [31:0] d);
    host_we = 1'b1; host_sel = s; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [1:0] s, logic [31:0] exp);
    host_sel = s;
    #1;
    chk(req, host_rdata, exp);
  endtask

  // responder: hold ready low for rdly cycles, accept, wait qdly, respond
  task automatic serve(int rdly, int qdly, bit f, logic [31:0] d);
    for (int i = 0; i < rdly; i++) @(negedge clk);
    sb_req_ready = 1'b1;
    @(negedge clk);
    sb_req_ready = 1'b0;
    for (int i = 0; i < qdly; i++) @(negedge clk);
    sb_rsp_valid = 1'b1; sb_rsp_fail = f; sb_rsp_data = d;
    @(negedge clk);
    sb_rsp_valid = 1'b0; sb_rsp_fail = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    rd_chk("R1 ctl", 2'd0, 32'h0);
    rd_chk("R1 addr", 2'd1, 32'h0);
    rd_chk("R1 data", 2'd2, 32'h0);
    chk("R1 no req", {31'b0, sb_req_valid}, 32'h0);

    // clock-unit write
    wr(2'd1, 32'hABCD_1234);
    wr(2'd2, 32'h55AA_0001);
    wr(2'd0, 32'h0000_0101);
    chk("R5 req raised", {31'b0, sb_req_valid}, 32'h1);
    chk("R4 opcode clk write", {29'b0, sb_req_opcode}, 32'h7);
    chk("R2 index", {16'b0, sb_req_index}, 32'h0000_ABCD);
    rd_chk("R5 busy set", 2'd0, 32'h0000_0101);
    wr(2'd1, 32'h1111_2222);            // dropped
    wr(2'd0, 32'h0001_0001);            // dropped
    rd_chk("R9 addr kept", 2'd1, 32'hABCD_1234);
    chk("R9 opcode kept", {29'b0, sb_req_opcode}, 32'h7);
    serve(1, 2, 1'b0, 32'hFFFF_FFFF);
    rd_chk("R6 busy clear", 2'd0, 32'h0000_0100);
    rd_chk("R8 write keeps data", 2'd2, 32'h55AA_0001);

    // PHY read that fails
    wr(2'd2, 32'h0);
    wr(2'd0, 32'h0001_0001);
    chk("R3 opcode phy read", {29'b0, sb_req_opcode}, 32'h2);
    serve(0, 1, 1'b1, 32'hDEAD_BEEF);
    rd_chk("R7 fail flag", 2'd0, 32'h0001_0002);
    rd_chk("R8 fail keeps data", 2'd2, 32'h0);

    // clock read that succeeds
    wr(2'd0, 32'h0000_0001);
    rd_chk("R7 fail cleared", 2'd0, 32'h0000_0001);
    chk("R3 opcode clk read", {29'b0, sb_req_opcode}, 32'h6);
    serve(2, 0, 1'b0, 32'h1234_5678);
    rd_chk("R8 read data", 2'd2, 32'h1234_5678);
    rd_chk("R6 idle ok", 2'd0, 32'h0000_0000);

    // control write without busy bit
    wr(2'd0, 32'h0001_0100);
    chk("R10 no req", {31'b0, sb_req_valid}, 32'h0);
    rd_chk("R10 fields", 2'd0, 32'h0001_0100);
    @(negedge clk);
    chk("R10 still idle", {31'b0, sb_req_valid}, 32'h0);

    // PHY write
    wr(2'd0, 32'h0001_0101);
    chk("R4 opcode phy write", {29'b0, sb_req_opcode}, 32'h3);
    chk("R4 wdata", sb_req_wdata, 32'h1234_5678);
    serve(0, 0, 1'b0, 32'h0);
    rd_chk("R6 done", 2'd0, 32'h0001_0100);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule